// File: doc/BRIEF.md
# Serial Clock Source Selector

This block supplies the bit timing for a serial port that runs either asynchronously or in clocked synchronous mode. A mode input and a two-bit clock-source select decide two things. The first is whether the bit enable comes from the internal divider's half-period tick or from the external clock pin. The second is what role the clock pin takes: left alone for general use, driven with a clock at the bit rate, read as a clock at sixteen times the bit rate, or carrying the synchronous shift clock in either direction.

The external pin is brought into the system clock domain through a synchronizer chain, and its rising edges are detected there. In asynchronous external mode the detected edges are divided down so that one enable is produced per bit period. In the driving modes the pin clock toggles on every half-period tick, which gives a 50% duty cycle. Settings that are not allowed produce neither an enable nor a driven pin, and they raise a flag that stays set.

Top module: `sclk_src_sel`

## Requirements
- R1: The source is decoded from {mode_sync, clk_sel[1], clk_sel[0]}. The settings 000, 001 and 100 use the internal tick. 010 takes the external pin at 16x the bit rate, and 110 takes the external pin as the shift clock. pin_oe is 1 only for 001 and 100.
- R2: With an internal source, the internal pin clock toggles on every cycle in which half_tick is 1. bit_en is 1 for one cycle on the same clock edge that sets the pin clock high, so K half ticks after reset give (K+1)/2 enables and K pin_out toggles when the pin is driven.
- R3: Under setting 000, pin_out and pin_oe stay 0 while bit_en is still produced from the internal tick.
- R4: Under setting 110, each rising edge of pin_in yields exactly one bit_en pulse. The pulse is high during the cycle after the third rising clock edge that follows the pin change.
- R5: Under setting 010, bit_en pulses once for every 16 rising edges of pin_in, on the 16th edge counted from reset.
- R6: In the external settings, half_tick has no effect on bit_en or pin_out. In the internal settings, pin_in has no effect on bit_en.
- R7: Under a reserved setting (011, 101, 111), pin_oe is 0 and bit_en stays 0. cfg_err becomes 1 on the next clock edge and stays 1 until reset, even after a valid setting returns.
- R8: After reset, bit_en, pin_out, pin_oe (under setting 000) and cfg_err are all 0.
- R9: bit_en is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sync | input | 1 | 0 asynchronous, 1 clocked synchronous |
| clk_sel | input | 2 | Clock-source select bits |
| half_tick | input | 1 | Half-bit-period tick from the internal divider |
| pin_in | input | 1 | Level read from the clock pin |
| bit_en | output | 1 | One-cycle bit enable for the shifter |
| pin_out | output | 1 | Value to drive on the clock pin |
| pin_oe | output | 1 | Output enable for the clock pin |
| cfg_err | output | 1 | Sticky flag for a reserved setting |

## Verification
Several properties are checked by the assertions on every cycle. A reserved setting keeps the pin undriven and the enable low, and the error flag latches. Enables never fall in back-to-back cycles. The driven pin clock changes only after a half tick, and the oversampling counter wraps only on the enable. Other behaviours need the bench's scenarios. These are the enable counts per tick or per pin edge in each setting, the three-edge latency of the synchronizer path, the one-in-sixteen division, and the fact that each mode ignores the stimulus of the other clock source.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
   typedef enum logic [2:0] {
      SRC_INT_QUIET,
      SRC_INT_DRIVE,
      SRC_EXT_OVS,
      SRC_SYNC_DRIVE,
      SRC_SYNC_EXT,
      SRC_BAD
   } src_e;
endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
   import sclk_pkg::*;
(
   input  logic       mode_sync,
   input  logic [1:0] clk_sel,
   output src_e       src,
   output logic       use_int,
   output logic       drive_pin,
   output logic       bad
);
   always_comb begin
      unique case ({mode_sync, clk_sel})
         3'b000:  src = SRC_INT_QUIET;
         3'b001:  src = SRC_INT_DRIVE;
         3'b010:  src = SRC_EXT_OVS;
         3'b100:  src = SRC_SYNC_DRIVE;
         3'b110:  src = SRC_SYNC_EXT;
         default: src = SRC_BAD;
      endcase
   end

   assign use_int   = (src == SRC_INT_QUIET) || (src == SRC_INT_DRIVE) || (src == SRC_SYNC_DRIVE);
   assign drive_pin = (src == SRC_INT_DRIVE) || (src == SRC_SYNC_DRIVE);
   assign bad       = (src == SRC_BAD);
endmodule

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise
);
   localparam int LEN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("sclk_edge_sync: STAGES must be at least 2");
   end

   logic [LEN-1:0] sh;

   for (genvar i = 0; i < LEN; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= pin_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

   a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/sclk_ovs_div.sv
module sclk_ovs_div #(
   parameter int RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic rise,
   output logic hit
);
   localparam int CNT_W = $clog2(RATIO);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RATIO - 1);

   if (RATIO < 2 || (RATIO & (RATIO - 1)) != 0) begin : g_bad_ratio
      $error("sclk_ovs_div: RATIO must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) cnt <= '0;
      else if (rise)         cnt <= cnt + 1'b1;
   end

   assign hit = active & rise & (cnt == CNT_MAX);

   a_r5_wrap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cnt == '0));
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(rise)) |-> $stable(cnt));
endmodule

// File: rtl/sclk_src_sel.sv
module sclk_src_sel
   import sclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OVS_RATIO   = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sync,
   input  logic [1:0] clk_sel,
   input  logic       half_tick,
   input  logic       pin_in,
   output logic       bit_en,
   output logic       pin_out,
   output logic       pin_oe,
   output logic       cfg_err
);
   src_e src;
   logic use_int, drive_pin, bad;
   logic rise, ovs_hit;
   logic ck_q, en_q, err_q, en_d;

   sclk_cfg_decode u_dec (
      .mode_sync (mode_sync),
      .clk_sel   (clk_sel),
      .src       (src),
      .use_int   (use_int),
      .drive_pin (drive_pin),
      .bad       (bad)
   );

   sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .rise   (rise)
   );

   sclk_ovs_div #(.RATIO(OVS_RATIO)) u_ovs (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (src == SRC_EXT_OVS),
      .rise   (rise),
      .hit    (ovs_hit)
   );

   always_comb begin
      unique case (src)
         SRC_INT_QUIET,
         SRC_INT_DRIVE,
         SRC_SYNC_DRIVE: en_d = half_tick & ~ck_q;
         SRC_SYNC_EXT:   en_d = rise;
         SRC_EXT_OVS:    en_d = ovs_hit;
         default:        en_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_q  <= 1'b0;
         en_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         en_q  <= en_d;
         err_q <= err_q | bad;
         if (!use_int)       ck_q <= 1'b0;
         else if (half_tick) ck_q <= ~ck_q;
      end
   end

   assign bit_en  = en_q;
   assign pin_out = ck_q & drive_pin;
   assign pin_oe  = drive_pin;
   assign cfg_err = err_q;

   logic resv_cfg;
   assign resv_cfg = ({mode_sync, clk_sel} == 3'b011) || ({mode_sync, clk_sel} == 3'b101) ||
                     ({mode_sync, clk_sel} == 3'b111);

   a_r7_resv_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      resv_cfg |-> !pin_oe);
   a_r7_resv_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      resv_cfg |=> (!bit_en && cfg_err));
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> !bit_en);
   a_r2_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && $past(pin_oe) && $past(rst_n) && (pin_out != $past(pin_out))) |-> $past(half_tick));
endmodule

// File: tb/sim_sclk_src_sel.sv
module sim_sclk_src_sel;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_sync = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic half_tick = 1'b0;
   logic pin_in = 1'b0;
   logic bit_en, pin_out, pin_oe, cfg_err;

   int n_chk = 0;
   int n_err = 0;
   int en_cnt = 0;
   int tog_cnt = 0;
   logic last_po = 1'b0;

   always #10 clk = ~clk;

   sclk_src_sel u0 (
      .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .clk_sel(clk_sel),
      .half_tick(half_tick), .pin_in(pin_in), .bit_en(bit_en),
      .pin_out(pin_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
   );

   always @(posedge clk) begin
      #5;
      if (bit_en === 1'b1) en_cnt++;
      if (pin_out !== last_po) tog_cnt++;
      last_po = pin_out;
   end

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_cfg(input logic [2:0] c);
      {mode_sync, clk_sel} = c;
   endtask

   task automatic do_reset(input logic [2:0] c);
      @(negedge clk);
      rst_n = 1'b0; half_tick = 1'b0; pin_in = 1'b0;
      set_cfg(c);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      en_cnt = 0; tog_cnt = 0;
   endtask

   task automatic ticks(input int k, input int p);
      for (int i = 0; i < k; i++) begin
         half_tick = 1'b1;
         @(negedge clk);
         half_tick = 1'b0;
         repeat (p - 1) @(negedge clk);
      end
   endtask

   task automatic edges(input int m, input int h);
      for (int i = 0; i < m; i++) begin
         pin_in = 1'b1;
         repeat (h) @(negedge clk);
         pin_in = 1'b0;
         repeat (h) @(negedge clk);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   function automatic int exp_int_en(input int k);
      return (k + 1) / 2;
   endfunction

   function automatic int exp_ext_en(input logic [2:0] c, input int m);
      return (c == 3'b010) ? m / 16 : m;
   endfunction

   initial begin
      #(20 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5eed);

      // R8 reset state
      do_reset(3'b000);
      chk("R8 bit_en", bit_en, 0);
      chk("R8 pin_out", pin_out, 0);
      chk("R8 pin_oe", pin_oe, 0);
      chk("R8 cfg_err", cfg_err, 0);

      // R1 output enable per setting
      set_cfg(3'b001); #1; chk("R1 oe 001", pin_oe, 1);
      set_cfg(3'b100); #1; chk("R1 oe 100", pin_oe, 1);
      set_cfg(3'b010); #1; chk("R1 oe 010", pin_oe, 0);
      set_cfg(3'b110); #1; chk("R1 oe 110", pin_oe, 0);
      set_cfg(3'b000); #1; chk("R1 oe 000", pin_oe, 0);

      // R3 quiet internal: enables, no pin activity
      do_reset(3'b000);
      ticks(10, 3); settle();
      chk("R3 enables", en_cnt, exp_int_en(10));
      chk("R3 toggles", tog_cnt, 0);

      // R2 enable aligned with rising pin clock
      do_reset(3'b001);
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0;
      chk("R2 pin high", pin_out, 1);
      chk("R2 enable", bit_en, 1);
      @(negedge clk);
      chk("R2 enable single", bit_en, 0);

      // R4 latency of external shift clock
      do_reset(3'b110);
      pin_in = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R4 not yet", bit_en, 0);
      @(negedge clk);
      chk("R4 third edge", bit_en, 1);
      @(negedge clk);
      chk("R4 one pulse", bit_en, 0);
      pin_in = 1'b0;

      // R5 exact 16th edge
      do_reset(3'b010);
      edges(15, 2); settle();
      chk("R5 none at 15", en_cnt, 0);
      edges(1, 2); settle();
      chk("R5 one at 16", en_cnt, 1);

      // R6 external ignores ticks, internal ignores pin
      do_reset(3'b110);
      ticks(8, 2); settle();
      chk("R6 ext ignores tick", en_cnt, 0);
      chk("R6 ext pin_out quiet", tog_cnt, 0);
      do_reset(3'b100);
      edges(6, 2); settle();
      chk("R6 int ignores pin", en_cnt, 0);

      // R7 reserved settings
      for (int r = 0; r < 3; r++) begin
         logic [2:0] c;
         c = (r == 0) ? 3'b011 : (r == 1) ? 3'b101 : 3'b111;
         do_reset(c);
         chk("R7 err set", cfg_err, 1);
         chk("R7 no oe", pin_oe, 0);
         ticks(6, 2); edges(20, 2); settle();
         chk("R7 no enable", en_cnt, 0);
         set_cfg(3'b001); settle();
         chk("R7 err sticky", cfg_err, 1);
      end

      // random mix of valid settings (R2 R4 R5 R9 implied by counts)
      for (int it = 0; it < 16; it++) begin
         logic [2:0] c;
         int sel, k, p, m, h;
         sel = $urandom_range(0, 4);
         c = (sel == 0) ? 3'b000 : (sel == 1) ? 3'b001 : (sel == 2) ? 3'b100 :
             (sel == 3) ? 3'b010 : 3'b110;
         do_reset(c);
         if (sel <= 2) begin
            k = $urandom_range(1, 30);
            p = $urandom_range(1, 5);
            ticks(k, p); settle();
            chk("R2 rand enables", en_cnt, exp_int_en(k));
            chk("R2 rand toggles", tog_cnt, (sel == 0) ? 0 : k);
         end else begin
            m = $urandom_range(1, 60);
            h = $urandom_range(2, 4);
            edges(m, h); settle();
            chk((sel == 3) ? "R5 rand enables" : "R4 rand enables", en_cnt, exp_ext_en(c, m));
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule